// File: doc/BRIEF.md
# Packed Colour Palette Lookup

This block stores a 256-colour palette for a display pipeline. Each palette entry is 16 bits wide. Two entries share one 32-bit storage word, so the whole palette occupies 128 words. A register bus reaches those words through a 512-byte window. Software loads and inspects the palette one whole word at a time. The bus always returns the raw word, exactly as it was written.

On the pixel side, the pipeline presents an 8-bit colour index together with a valid strobe. One clock later it receives a 24-bit colour. The block widens each 5-bit colour field of the selected entry to 8 bits. The top bit of each entry is an intensity flag, and it plays no part in the output colour. A swap input exchanges the red and blue channels, for panels wired in blue-green-red order.

The storage has one read/write port for the bus and one read port for the pixel lookup, so it maps onto a dual-port block RAM. The palette contents are not cleared by reset.

Top module: `packed_palette`

## Requirements
- R1: Only bus byte offsets 0x200 to 0x3FF reach the palette. The word index is (offset − 0x200) >> 2, and the two low address bits are ignored. A write outside the window changes no palette word. A read outside the window returns zero.
- R2: An in-window bus read (bus_en=1, bus_we=0) presents the full 32-bit stored word on bus_rdata after the next rising edge. bus_rdata keeps its value on cycles without a read, including cycles with a bus write.
- R3: Palette entry 2n is bits 15:0 of word n, and entry 2n+1 is bits 31:16 of word n. Index bit 0 selects the half.
- R4: Within an entry, bits 4:0 are red, bits 9:5 are green and bits 14:10 are blue. Each channel is its field shifted left by 3, so its low three bits are zero. pix_rgb is {red[23:16], green[15:8], blue[7:0]}.
- R5: Entry bit 15 (intensity) has no effect on pix_rgb.
- R6: A lookup sampled with pix_valid=1 at a rising edge shows its colour on pix_rgb right after that edge.
- R7: pix_rgb keeps its value on every edge where pix_valid is 0.
- R8: If a bus write and a pixel lookup address the same word at the same edge, the lookup returns the word's previous contents. A later lookup returns the new contents.
- R9: With swap_rb=1 sampled together with the index, the blue field drives bits 23:16 and the red field drives bits 7:0. Green stays in the middle.
- R10: A synchronous reset drives pix_rgb and bus_rdata to zero. The palette words keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pix_valid | input | 1 | Lookup strobe |
| pix_idx | input | 8 | Colour index |
| swap_rb | input | 1 | Exchange red and blue at the output |
| pix_rgb | output | 24 | Looked-up colour |

## Verification
A storage word that is wrong or misaddressed shows up on the very next read of that word, and on the next lookup of either of its entries. Randomised bus readback and per-entry lookups therefore expose it within a few cycles. A wrong half-select, field order or swap flag corrupts specific channel bits on pix_rgb one cycle after the index. Directed single-field patterns make that corruption unambiguous. A pixel read port that returns new data on a collision, or that loses its hold, changes pix_rgb at the cycle a reference model says it must stay old or unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned FIELD_W  = 5;
  localparam int unsigned CHAN_W   = 8;
  localparam int unsigned N_FIELDS = 3;

  function automatic logic [CHAN_W-1:0] widen(input logic [FIELD_W-1:0] f);
    return {f, {(CHAN_W-FIELD_W){1'b0}}};
  endfunction
endpackage

// File: rtl/pal_word_ram.sv
module pal_word_ram #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             b_en,
  input  logic [AW-1:0]    b_addr,
  output logic [WIDTH-1:0] b_rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  // port A: bus side, read or write
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_rdata     <= mem[a_addr];
    end
  end

  // port B: pixel side, sees pre-write contents on a collision
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned WORDS    = 128,
  parameter int unsigned WIN_BASE = 'h200,
  localparam int unsigned WIDX_W    = $clog2(WORDS),
  localparam int unsigned BYTE_SH   = $clog2(WORD_W/8),
  localparam int unsigned WIN_BYTES = WORDS*(WORD_W/8),
  localparam int unsigned WIN_END   = WIN_BASE + WIN_BYTES
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              in_win,
  output logic              wr_hit,
  output logic              rd_any,
  output logic              rd_hit,
  output logic [WIDX_W-1:0] word_idx
);
  logic [ADDR_W-1:0] rel;
  logic              rel_bits_unused;

  assign in_win = (32'(bus_addr) >= WIN_BASE) && (32'(bus_addr) < WIN_END);
  assign rel    = bus_addr - ADDR_W'(WIN_BASE);
  assign word_idx = rel[BYTE_SH +: WIDX_W];
  assign rel_bits_unused = ^{rel[BYTE_SH-1:0], rel[ADDR_W-1:BYTE_SH+WIDX_W]};

  assign wr_hit = bus_en &&  bus_we && in_win;
  assign rd_any = bus_en && !bus_we;
  assign rd_hit = rd_any && in_win;
endmodule

// File: rtl/pal_entry_expand.sv
module pal_entry_expand
  import pal_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ENTRY_W = 16,
  localparam int unsigned PER_WORD = WORD_W/ENTRY_W,
  localparam int unsigned HALF_W   = $clog2(PER_WORD)
) (
  input  logic [WORD_W-1:0]          word,
  input  logic [HALF_W-1:0]          half,
  input  logic                       swap,
  output logic [N_FIELDS*CHAN_W-1:0] rgb
);
  logic [ENTRY_W-1:0] ent [PER_WORD];
  logic [ENTRY_W-1:0] sel;
  logic [CHAN_W-1:0]  chan [N_FIELDS];
  logic               intensity_unused;

  for (genvar i = 0; i < PER_WORD; i++) begin : g_split
    assign ent[i] = word[i*ENTRY_W +: ENTRY_W];
  end

  assign sel = ent[half];
  assign intensity_unused = sel[ENTRY_W-1];

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_chan
    assign chan[f] = widen(sel[f*FIELD_W +: FIELD_W]);
  end

  // field 0 is red, field 2 is blue
  assign rgb = swap ? {chan[2], chan[1], chan[0]}
                    : {chan[0], chan[1], chan[2]};
endmodule

// File: rtl/packed_palette.sv
module packed_palette
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ENTRY_W  = 16,
  parameter int unsigned ENTRIES  = 256,
  parameter int unsigned WIN_BASE = 'h200,
  localparam int unsigned PER_WORD = WORD_W/ENTRY_W,
  localparam int unsigned WORDS    = ENTRIES/PER_WORD,
  localparam int unsigned WIDX_W   = $clog2(WORDS),
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned HALF_W   = $clog2(PER_WORD),
  localparam int unsigned RGB_W    = N_FIELDS*CHAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              swap_rb,
  output logic [RGB_W-1:0]  pix_rgb
);
  logic              in_win, wr_hit, rd_any, rd_hit;
  logic [WIDX_W-1:0] word_idx;
  logic [WORD_W-1:0] ram_a_q, ram_b_q;
  logic              rd_zero_q;
  logic              pix_live_q;
  logic [HALF_W-1:0] half_q;
  logic              swap_q;
  logic [RGB_W-1:0]  rgb_x;

  pal_bus_decode #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .WIN_BASE(WIN_BASE)
  ) i_dec (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .in_win(in_win), .wr_hit(wr_hit), .rd_any(rd_any), .rd_hit(rd_hit),
    .word_idx(word_idx)
  );

  pal_word_ram #(.WORDS(WORDS), .WIDTH(WORD_W)) i_ram (
    .clk(clk),
    .a_en(wr_hit || rd_hit), .a_we(wr_hit), .a_addr(word_idx),
    .a_wdata(bus_wdata), .a_rdata(ram_a_q),
    .b_en(pix_valid), .b_addr(pix_idx[IDX_W-1:HALF_W]), .b_rdata(ram_b_q)
  );

  // bus read qualifier: zero after reset or after an out-of-window read
  always_ff @(posedge clk) begin
    if (rst)         rd_zero_q <= 1'b1;
    else if (rd_any) rd_zero_q <= !in_win;
  end

  assign bus_rdata = rd_zero_q ? '0 : ram_a_q;

  // pixel side control registered alongside the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_live_q <= 1'b0;
      half_q     <= '0;
      swap_q     <= 1'b0;
    end else if (pix_valid) begin
      pix_live_q <= 1'b1;
      half_q     <= pix_idx[HALF_W-1:0];
      swap_q     <= swap_rb;
    end
  end

  pal_entry_expand #(.WORD_W(WORD_W), .ENTRY_W(ENTRY_W)) i_exp (
    .word(ram_b_q), .half(half_q), .swap(swap_q), .rgb(rgb_x)
  );

  assign pix_rgb = pix_live_q ? rgb_x : '0;

  // R1
  oow_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_any && !in_win) |=> (bus_rdata == '0));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_hit) && rd_hit && (word_idx == $past(word_idx)))
      |=> (bus_rdata == $past(bus_wdata, 2)));

  // R7
  pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(pix_rgb));
endmodule

// File: tb/test_packed_palette.sv
module test_packed_palette;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        swap_rb = 1'b0;
  logic [23:0] pix_rgb;

  int total = 0;
  int bad   = 0;
  logic [31:0] shadow [128];

  always #(CLK_P/2) clk = ~clk;

  packed_palette i_packed_palette (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .swap_rb(swap_rb),
    .pix_rgb(pix_rgb)
  );

  function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic h, input logic sw);
    logic [15:0] e;
    logic [7:0] r, g, b;
    e = h ? w[31:16] : w[15:0];
    r = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    b = {e[14:10], 3'b000};
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic lookup(input logic [7:0] i, input logic sw, output logic [23:0] c);
    @(negedge clk);
    pix_valid = 1'b1; pix_idx = i; swap_rb = sw;
    @(negedge clk);
    pix_valid = 1'b0;
    c = pix_rgb;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P*150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] rd, v;
    logic [23:0] c;
    int unsigned seed;
    seed = 32'd2024;
    v = $urandom(seed);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset pix_rgb", {8'h0, pix_rgb}, 32'h0);
    chk("R10 reset bus_rdata", bus_rdata, 32'h0);

    // R1: load whole window via word offsets, low address bits random
    for (int n = 0; n < 128; n++) begin
      shadow[n] = $urandom;
      bwrite(12'h200 + 12'(n*4) + 12'($urandom_range(0, 3)), shadow[n]);
    end
    // R1: writes just outside the window
    bwrite(12'h1FC, 32'hDEADBEEF);
    bwrite(12'h400, 32'hCAFEF00D);
    bwrite(12'h000, 32'h12345678);

    // R2: readback of every word
    for (int n = 0; n < 128; n++) begin
      bread(12'h200 + 12'(n*4), rd);
      chk("R2 readback", rd, shadow[n]);
    end
    bread(12'h200, rd);
    chk("R1 first word untouched", rd, shadow[0]);
    bread(12'h3FC, rd);
    chk("R1 last word untouched", rd, shadow[127]);

    // R1 out-of-window read is zero; R2 hold on idle and on write
    bread(12'h400, rd);
    chk("R1 oow read zero", rd, 32'h0);
    bread(12'h208, rd);
    @(negedge clk);
    chk("R2 hold idle", bus_rdata, shadow[2]);
    bwrite(12'h20C, shadow[3]);
    chk("R2 hold across write", bus_rdata, shadow[2]);

    // R3 R4 R6 R9 random lookups
    for (int k = 0; k < 200; k++) begin
      logic [7:0] i;
      logic sw;
      i = 8'($urandom);
      sw = 1'($urandom);
      lookup(i, sw, c);
      chk("R3/R4/R9 lookup", {8'h0, c}, {8'h0, exp_rgb(shadow[i[7:1]], i[0], sw)});
    end

    // R4 directed field patterns, R3 halves
    bwrite(12'h210, 32'h03E0_001F);
    lookup(8'd8, 1'b0, c);
    chk("R4 red field", {8'h0, c}, 32'h00F8_0000);
    lookup(8'd9, 1'b0, c);
    chk("R4 green field R3 high half", {8'h0, c}, 32'h0000_F800);
    bwrite(12'h214, 32'hFC00_7C00);
    lookup(8'd10, 1'b0, c);
    chk("R4 blue field", {8'h0, c}, 32'h0000_00F8);
    lookup(8'd10, 1'b1, c);
    chk("R9 swap blue to top", {8'h0, c}, 32'h00F8_0000);
    // R5 intensity bit ignored
    lookup(8'd11, 1'b0, c);
    chk("R5 intensity ignored", {8'h0, c}, 32'h0000_00F8);
    shadow[4] = 32'h03E0_001F;
    shadow[5] = 32'hFC00_7C00;

    // R7 hold with valid low while index changes
    lookup(8'd8, 1'b0, c);
    @(negedge clk);
    pix_idx = 8'd11; swap_rb = 1'b1;
    @(negedge clk);
    chk("R7 hold", {8'h0, pix_rgb}, 32'h00F8_0000);

    // R8 collision: write word 6 and look up entry 13 at the same edge
    v = 32'h1234_4321;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h218; bus_wdata = v;
    pix_valid = 1'b1; pix_idx = 8'd13; swap_rb = 1'b0;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; pix_valid = 1'b0;
    chk("R8 collision old data", {8'h0, pix_rgb}, {8'h0, exp_rgb(shadow[6], 1'b1, 1'b0)});
    shadow[6] = v;
    lookup(8'd13, 1'b0, c);
    chk("R8 new data after", {8'h0, c}, {8'h0, exp_rgb(v, 1'b1, 1'b0)});

    // R10 second reset keeps palette
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 rst pix zero", {8'h0, pix_rgb}, 32'h0);
    chk("R10 rst rdata zero", bus_rdata, 32'h0);
    bread(12'h218, rd);
    chk("R10 palette retained", rd, shadow[6]);
    lookup(8'd12, 1'b1, c);
    chk("R10 lookup retained", {8'h0, c}, {8'h0, exp_rgb(shadow[6], 1'b0, 1'b1)});

    finish_up();
  end
endmodule